// File: doc/BRIEF.md
# Bit-PLRU Victim Way Allocator

This block chooses which way of a set-associative cache set should receive a new line. It also computes the most-recently-used (MRU) vector to write back after an access. The cache pipeline presents the valid bits and MRU bits it read for the set, and says whether the access is a hit (with a one-hot hit-way vector) or a fill. The allocator returns a one-hot victim way and the next MRU vector for that set. Both results come out of a register one cycle later by default, or straight through when the output register is disabled by parameter.

Replacement uses one status bit per way. A fill takes a free (invalid) way whenever one exists. Only when every way holds a line does the allocator fall back to the MRU bits and pick the lowest-numbered way whose MRU bit is clear. Every access marks the touched way as recently used. When that would leave no clear bit in the set, the other bits are wiped so that only the touched way stays marked. The way count is a parameter, and the priority logic is generated to match it.

Top module: `plru_victim_alloc`

## Requirements
- R1: `victim_o` is one-hot when a fill was requested and all zeros when it was not. Bit i stands for way i.
- R2: On a fill where some way is invalid (`way_valid_i` bit clear), the victim is the lowest-numbered invalid way, whatever the MRU bits are.
- R3: On a fill where all ways are valid, the victim is the lowest-numbered way whose MRU bit is 0.
- R4: On a fill where all ways are valid and the MRU input is all ones (corrupted state), the victim is way 0.
- R5: On an access (hit or fill), the accessed way's bit is set in `mru_next_o`, and all other bits keep their input value, unless R6 applies.
- R6: If setting the accessed bit would make every MRU bit 1, `mru_next_o` has only the accessed way's bit set.
- R7: On a hit the accessed way is `hit_way_i`, and on a fill alone it is the victim. When hit and fill are both asserted, the hit way is the accessed way for the MRU update, and `victim_o` is still reported.
- R8: With neither hit nor fill asserted, `mru_next_o` equals `way_mru_i` and `victim_o` is zero.
- R9: With the default output register, results appear one clock after the inputs are sampled. While `rst_n` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| way_valid_i | input | NUM_WAYS | Per-way valid bits of the set |
| way_mru_i | input | NUM_WAYS | Per-way MRU bits of the set as read |
| hit_way_i | input | NUM_WAYS | One-hot hit way, meaningful when `hit_i` is high |
| hit_i | input | 1 | Access is a read or write hit |
| fill_i | input | 1 | Access is a fill that needs a way |
| victim_o | output | NUM_WAYS | One-hot chosen way, zero without a fill |
| mru_next_o | output | NUM_WAYS | MRU vector to write back for the set |

## Verification
The bench targets three corner cases:
- **Free way with cold MRU bits.** A set with a free way whose MRU bits point elsewhere shows whether free-way priority is honoured. A design that consulted MRU first would evict a live line.
- **Saturating accesses.** Accesses that fill the last clear MRU bit, on both a hit and a fill, expose a missing or inverted saturation reset. Such a design would either leave an all-ones vector or clear the accessed bit.
- **All-ones MRU input.** A fully valid set with MRU all ones checks the way-0 fallback. A wrong design would return an empty or multi-hot victim.

Hit and fill asserted together check that the hit way, not the victim, is marked. An exhaustive sweep of valid and MRU patterns catches priority encoders that favour the highest index.

// File: rtl/plru_pkg.sv
package plru_pkg;
   // Legal range for the way count of the allocator.
   localparam int unsigned PLRU_MIN_WAYS = 2;
   localparam int unsigned PLRU_MAX_WAYS = 64;
endpackage

// File: rtl/plru_first_set.sv
// Lowest-index-first priority picker: one-hot of the lowest set request bit.
module plru_first_set #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] req_i,
   output logic [WIDTH-1:0] pick_o,
   output logic             any_o
);
   logic [WIDTH:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar g = 0; g < WIDTH; g++) begin : g_chain
         assign pick_o[g]   = req_i[g] & ~seen[g];
         assign seen[g + 1] = seen[g] | req_i[g];
      end
   endgenerate

   assign any_o = seen[WIDTH];
endmodule

// File: rtl/plru_victim_sel.sv
// Victim choice: free ways first, then lowest cold way, then way 0 as fallback.
module plru_victim_sel #(
   parameter int unsigned NUM_WAYS = 4
) (
   input  logic [NUM_WAYS-1:0] valid_i,
   input  logic [NUM_WAYS-1:0] mru_i,
   input  logic                fill_i,
   output logic [NUM_WAYS-1:0] victim_o
);
   localparam logic [NUM_WAYS-1:0] WAY0_ONEHOT = NUM_WAYS'(1);

   logic [NUM_WAYS-1:0] free_pick;
   logic [NUM_WAYS-1:0] cold_pick;
   logic                free_any;
   logic                cold_any;

   plru_first_set #(.WIDTH(NUM_WAYS)) u_free (
      .req_i  (~valid_i),
      .pick_o (free_pick),
      .any_o  (free_any)
   );

   plru_first_set #(.WIDTH(NUM_WAYS)) u_cold (
      .req_i  (~mru_i),
      .pick_o (cold_pick),
      .any_o  (cold_any)
   );

   always_comb begin
      if (!fill_i)       victim_o = '0;
      else if (free_any) victim_o = free_pick;
      else if (cold_any) victim_o = cold_pick;
      else               victim_o = WAY0_ONEHOT;
   end
endmodule

// File: rtl/plru_mru_update.sv
// Next MRU vector: mark the accessed way, and reset the others on saturation.
module plru_mru_update #(
   parameter int unsigned NUM_WAYS = 4
) (
   input  logic [NUM_WAYS-1:0] mru_i,
   input  logic [NUM_WAYS-1:0] acc_way_i,
   input  logic                acc_en_i,
   output logic [NUM_WAYS-1:0] mru_next_o
);
   logic [NUM_WAYS-1:0] marked;

   assign marked = mru_i | acc_way_i;

   always_comb begin
      if (!acc_en_i)   mru_next_o = mru_i;
      else if (&marked) mru_next_o = acc_way_i;
      else             mru_next_o = marked;
   end
endmodule

// File: rtl/plru_victim_alloc.sv
module plru_victim_alloc #(
   parameter int unsigned NUM_WAYS = 4,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAYS-1:0] way_valid_i,
   input  logic [NUM_WAYS-1:0] way_mru_i,
   input  logic [NUM_WAYS-1:0] hit_way_i,
   input  logic                hit_i,
   input  logic                fill_i,
   output logic [NUM_WAYS-1:0] victim_o,
   output logic [NUM_WAYS-1:0] mru_next_o
);
   import plru_pkg::*;

   generate
      if (NUM_WAYS < PLRU_MIN_WAYS || NUM_WAYS > PLRU_MAX_WAYS) begin : g_bad_ways
         $error("plru_victim_alloc: NUM_WAYS out of range");
      end
   endgenerate

   logic [NUM_WAYS-1:0] victim_c;
   logic [NUM_WAYS-1:0] acc_way_c;
   logic                acc_en_c;
   logic [NUM_WAYS-1:0] mru_next_c;

   plru_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_sel (
      .valid_i  (way_valid_i),
      .mru_i    (way_mru_i),
      .fill_i   (fill_i),
      .victim_o (victim_c)
   );

   // A hit names the touched way; otherwise the fill victim is touched.
   assign acc_way_c = hit_i ? hit_way_i : victim_c;
   assign acc_en_c  = hit_i | fill_i;

   plru_mru_update #(.NUM_WAYS(NUM_WAYS)) u_upd (
      .mru_i      (way_mru_i),
      .acc_way_i  (acc_way_c),
      .acc_en_i   (acc_en_c),
      .mru_next_o (mru_next_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               victim_o   <= '0;
               mru_next_o <= '0;
            end else begin
               victim_o   <= victim_c;
               mru_next_o <= mru_next_c;
            end
         end

         // R1
         victim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(victim_o));

         // R1
         no_fill_no_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !fill_i |=> (victim_o == '0));

         // R2
         free_way_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_i && !(&way_valid_i)) |=> ((victim_o & $past(way_valid_i)) == '0));

         // R5
         hit_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i && $onehot(hit_way_i)) |=> ((mru_next_o & $past(hit_way_i)) == $past(hit_way_i)));

         // R6
         never_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_i || (hit_i && $onehot(hit_way_i))) |=> !(&mru_next_o));

         // R8
         idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit_i && !fill_i) |=> (mru_next_o == $past(way_mru_i)));
      end else begin : g_comb
         assign victim_o   = victim_c;
         assign mru_next_o = mru_next_c;
      end
   endgenerate
endmodule

// File: tb/sim_plru_victim_alloc.sv
module sim_plru_victim_alloc;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] way_valid_i = '0;
   logic [NW-1:0] way_mru_i = '0;
   logic [NW-1:0] hit_way_i = '0;
   logic          hit_i = 1'b0;
   logic          fill_i = 1'b0;
   logic [NW-1:0] victim_o;
   logic [NW-1:0] mru_next_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   plru_victim_alloc #(.NUM_WAYS(NW), .OUT_REG(1'b1)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .way_valid_i(way_valid_i),
      .way_mru_i  (way_mru_i),
      .hit_way_i  (hit_way_i),
      .hit_i      (hit_i),
      .fill_i     (fill_i),
      .victim_o   (victim_o),
      .mru_next_o (mru_next_o)
   );

   task automatic chk(input string req, input logic [NW-1:0] act, input logic [NW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Expected victim from the requirements (R1..R4).
   function automatic logic [NW-1:0] exp_victim(input logic [NW-1:0] v, input logic [NW-1:0] m,
                                                input logic f);
      if (!f) return '0;
      for (int i = 0; i < NW; i++) if (!v[i]) return NW'(1) << i;
      for (int i = 0; i < NW; i++) if (!m[i]) return NW'(1) << i;
      return NW'(1);
   endfunction

   // Expected next MRU (R5..R8).
   function automatic logic [NW-1:0] exp_mru(input logic [NW-1:0] m, input logic [NW-1:0] acc,
                                             input logic en);
      logic [NW-1:0] s;
      if (!en) return m;
      s = m | acc;
      if (s == {NW{1'b1}}) return acc;
      return s;
   endfunction

   // Apply one access; outputs are sampled one clock later (R9).
   task automatic apply(input logic [NW-1:0] v, input logic [NW-1:0] m, input logic [NW-1:0] hw,
                        input logic h, input logic f,
                        output logic [NW-1:0] vic, output logic [NW-1:0] mn);
      @(negedge clk);
      way_valid_i = v; way_mru_i = m; hit_way_i = hw; hit_i = h; fill_i = f;
      @(posedge clk);
      #1;
      vic = victim_o;
      mn  = mru_next_o;
   endtask

   task automatic t_reset;
      @(negedge clk);
      way_valid_i = 4'b1111; way_mru_i = 4'b0101; fill_i = 1'b1;
      @(posedge clk); #1;
      chk("R9 reset victim", victim_o, 4'b0000);
      chk("R9 reset mru", mru_next_o, 4'b0000);
      @(negedge clk);
      fill_i = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_free_first;
      logic [NW-1:0] vc, mn;
      apply(4'b1011, 4'b0000, 4'b0000, 1'b0, 1'b1, vc, mn);
      chk("R2 free way2", vc, 4'b0100);
      chk("R5 fill marks way2", mn, 4'b0100);
      apply(4'b0000, 4'b1110, 4'b0000, 1'b0, 1'b1, vc, mn);
      chk("R2 empty set way0", vc, 4'b0001);
      chk("R6 fill saturates", mn, 4'b0001);
      apply(4'b0111, 4'b0000, 4'b0000, 1'b0, 1'b1, vc, mn);
      chk("R2 free way3 over cold mru", vc, 4'b1000);
   endtask

   task automatic t_mru_pick;
      logic [NW-1:0] vc, mn;
      apply(4'b1111, 4'b1101, 4'b0000, 1'b0, 1'b1, vc, mn);
      chk("R3 lowest cold way1", vc, 4'b0010);
      chk("R6 fill last cold way", mn, 4'b0010);
      apply(4'b1111, 4'b0110, 4'b0000, 1'b0, 1'b1, vc, mn);
      chk("R3 lowest cold way0", vc, 4'b0001);
      chk("R5 fill sets way0", mn, 4'b0111);
   endtask

   task automatic t_corrupt;
      logic [NW-1:0] vc, mn;
      apply(4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b1, vc, mn);
      chk("R4 all-ones fallback", vc, 4'b0001);
      chk("R4 all-ones mru", mn, 4'b0001);
   endtask

   task automatic t_hits;
      logic [NW-1:0] vc, mn;
      apply(4'b1111, 4'b0001, 4'b0100, 1'b1, 1'b0, vc, mn);
      chk("R5 hit keeps others", mn, 4'b0101);
      chk("R1 hit no victim", vc, 4'b0000);
      apply(4'b1111, 4'b1011, 4'b0100, 1'b1, 1'b0, vc, mn);
      chk("R6 hit saturation", mn, 4'b0100);
      apply(4'b1111, 4'b0000, 4'b1000, 1'b1, 1'b1, vc, mn);
      chk("R7 hit+fill victim", vc, 4'b0001);
      chk("R7 hit+fill marks hit way", mn, 4'b1000);
   endtask

   task automatic t_idle;
      logic [NW-1:0] vc, mn;
      apply(4'b0011, 4'b1010, 4'b0001, 1'b0, 1'b0, vc, mn);
      chk("R8 idle mru", mn, 4'b1010);
      chk("R8 idle victim", vc, 4'b0000);
   endtask

   task automatic t_sweep;
      logic [NW-1:0] vc, mn, ev;
      for (int v = 0; v < 16; v++) begin
         for (int m = 0; m < 16; m++) begin
            apply(NW'(v), NW'(m), 4'b0000, 1'b0, 1'b1, vc, mn);
            ev = exp_victim(NW'(v), NW'(m), 1'b1);
            chk("R1 R2 R3 sweep victim", vc, ev);
            chk("R5 R6 sweep mru", mn, exp_mru(NW'(m), ev, 1'b1));
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_free_first();
      t_mru_pick();
      t_corrupt();
      t_hits();
      t_idle();
      t_sweep();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule